// File: doc/BRIEF.md
# Debug Exception Cause Arbiter

This block sits at the exception stage of a processor pipeline. For each instruction it receives the debug events raised against that instruction. The possible events are an instruction-count trigger, an instruction-address breakpoint hit, a data breakpoint hit from one of several address comparators, and a software break instruction in either its wide or its narrow encoding. The comparators and decoders that produce these events sit outside the block.

The block first compares the current interrupt level with a fixed debug level of 6. When the level is at or above 6, every event is dropped. Otherwise the block picks one winning cause by fixed priority and accepts the exception. On the following edge it registers three values: the cause word, the PC of the faulting instruction, and the new low status field (mode bit set, level 6). It also raises a redirect strobe for exactly one cycle so that fetch can move to the debug vector.

Top module: `dbg_cause_arb`

## Requirements
- R1: An exception is accepted when `evtValid` is high, at least one event input is active and `curLevel` is 5 or lower. The edge that captures it drives `vecRedirect` high for that one cycle only. `vecRedirect` is low in every cycle that follows an edge with no accepted exception.
- R2: When `curLevel` is 6 or higher, every event is ignored. `vecRedirect` stays low, and `causeOut`, `epcOut` and `psLowOut` keep their previous values.
- R3: On an accepted exception, `psLowOut` becomes 5'h16. Bit 4 is the exception-mode bit and bits 3:0 hold the level 6.
- R4: On an accepted exception, `epcOut` becomes the `evtPc` presented with the events.
- R5: The low five bits of `causeOut` encode the cause as follows: instruction count 0x01, instruction breakpoint 0x02, data breakpoint 0x04, wide software break 0x08, narrow software break 0x10. All other bits are zero unless R6 applies.
- R6: For a data breakpoint, `causeOut` bits starting at bit 8 hold the index of the matching comparator. When several comparators hit together, the lowest index is reported.
- R7: Exactly one cause bit is set per exception. The priority order is instruction count, then instruction breakpoint, then data breakpoint, then wide break, then narrow break. An instruction breakpoint together with a software break therefore reports 0x02.
- R8: While `rstN` is low at a clock edge, `causeOut`, `epcOut`, `psLowOut` and `vecRedirect` are cleared to zero.
- R9: With `evtValid` low, or with no event input active, the outputs keep their values and `vecRedirect` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtValid | input | 1 | Instruction at this stage is valid |
| evtPc | input | ADDR_W | PC of that instruction |
| curLevel | input | LEVEL_W | Current interrupt level |
| iCountHit | input | 1 | Instruction-count trigger |
| iBreakHit | input | 1 | Instruction-address breakpoint hit |
| dBreakHit | input | NUM_DBREAK | Data breakpoint comparator hits |
| swBreakWide | input | 1 | Wide software break instruction |
| swBreakNarrow | input | 1 | Narrow software break instruction |
| causeOut | output | 8+IDX_W | Registered cause word |
| epcOut | output | ADDR_W | Registered debug exception PC |
| psLowOut | output | 5 | Registered new status low field |
| vecRedirect | output | 1 | One-cycle redirect to the debug vector |

## Verification
The two functions that can meet in one cycle are the priority selection and the level mask. In practice this means several event inputs are active on the same instruction. The bench drives those collisions on purpose: an instruction breakpoint together with a wide break, the count trigger together with the instruction and data breakpoints, a data breakpoint together with a software break, and both data comparators at once. In each case it checks that only the expected single cause bit appears, with the correct comparator index. The same multi-event inputs are then repeated at levels 6 and 7. There the bench checks that the redirect stays low and that the cause, PC and status outputs still hold their earlier values.

// File: rtl/dbg_cause_pkg.sv
package dbg_cause_pkg;
  localparam int DEBUG_LEVEL = 6;
  localparam logic [4:0] MODE_BIT = 5'h10;
  localparam int BIT_ICOUNT = 0;
  localparam int BIT_IBREAK = 1;
  localparam int BIT_DBREAK = 2;
  localparam int BIT_SWWIDE = 3;
  localparam int BIT_SWNARROW = 4;
  localparam int DBIDX_LSB = 8;

  typedef struct packed {
    logic take;
    logic selICount;
    logic selIBreak;
    logic selDBreak;
    logic selSwWide;
    logic selSwNarrow;
  } dbgStrobe_t;
endpackage

// File: rtl/dbg_cause_ctrl.sv
module dbg_cause_ctrl
  import dbg_cause_pkg::*;
#(
  parameter int LEVEL_W = 4
) (
  input  logic               evtValid,
  input  logic [LEVEL_W-1:0] curLevel,
  input  logic               iCountHit,
  input  logic               iBreakHit,
  input  logic               dBreakAny,
  input  logic               swBreakWide,
  input  logic               swBreakNarrow,
  output dbgStrobe_t         strobes
);
  localparam logic [LEVEL_W-1:0] DBG_LVL = LEVEL_W'(DEBUG_LEVEL);

  logic levelOpen;
  logic anyEvt;

  assign levelOpen = (curLevel < DBG_LVL);
  assign anyEvt = iCountHit | iBreakHit | dBreakAny | swBreakWide | swBreakNarrow;

  always_comb begin
    strobes = '0;
    strobes.take = evtValid & levelOpen & anyEvt;
    if (strobes.take) begin
      if (iCountHit)         strobes.selICount = 1'b1;
      else if (iBreakHit)    strobes.selIBreak = 1'b1;
      else if (dBreakAny)    strobes.selDBreak = 1'b1;
      else if (swBreakWide)  strobes.selSwWide = 1'b1;
      else                   strobes.selSwNarrow = 1'b1;
    end
  end
endmodule

// File: rtl/dbg_cause_dp.sv
module dbg_cause_dp
  import dbg_cause_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NUM_DBREAK = 2,
  localparam int IDX_W = (NUM_DBREAK > 1) ? $clog2(NUM_DBREAK) : 1,
  localparam int CAUSE_W = DBIDX_LSB + IDX_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dbgStrobe_t            strobes,
  input  logic [ADDR_W-1:0]     evtPc,
  input  logic [NUM_DBREAK-1:0] dBreakHit,
  output logic [CAUSE_W-1:0]    causeOut,
  output logic [ADDR_W-1:0]     epcOut,
  output logic [4:0]            psLowOut,
  output logic                  vecRedirect
);
  logic [IDX_W-1:0]   dbIdx;
  logic [CAUSE_W-1:0] nextCause;

  always_comb begin
    dbIdx = '0;
    for (int i = NUM_DBREAK - 1; i >= 0; i--) begin
      if (dBreakHit[i]) dbIdx = IDX_W'(i);
    end
  end

  always_comb begin
    nextCause = '0;
    nextCause[BIT_ICOUNT]   = strobes.selICount;
    nextCause[BIT_IBREAK]   = strobes.selIBreak;
    nextCause[BIT_DBREAK]   = strobes.selDBreak;
    nextCause[BIT_SWWIDE]   = strobes.selSwWide;
    nextCause[BIT_SWNARROW] = strobes.selSwNarrow;
    if (strobes.selDBreak) nextCause[DBIDX_LSB +: IDX_W] = dbIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      causeOut    <= '0;
      epcOut      <= '0;
      psLowOut    <= '0;
      vecRedirect <= 1'b0;
    end else begin
      vecRedirect <= strobes.take;
      if (strobes.take) begin
        causeOut <= nextCause;
        epcOut   <= evtPc;
        psLowOut <= MODE_BIT | 5'(DEBUG_LEVEL);
      end
    end
  end
endmodule

// File: rtl/dbg_cause_arb.sv
module dbg_cause_arb
  import dbg_cause_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEVEL_W = 4,
  parameter int NUM_DBREAK = 2,
  localparam int IDX_W = (NUM_DBREAK > 1) ? $clog2(NUM_DBREAK) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  evtValid,
  input  logic [ADDR_W-1:0]     evtPc,
  input  logic [LEVEL_W-1:0]    curLevel,
  input  logic                  iCountHit,
  input  logic                  iBreakHit,
  input  logic [NUM_DBREAK-1:0] dBreakHit,
  input  logic                  swBreakWide,
  input  logic                  swBreakNarrow,
  output logic [8+IDX_W-1:0]    causeOut,
  output logic [ADDR_W-1:0]     epcOut,
  output logic [4:0]            psLowOut,
  output logic                  vecRedirect
);
  dbgStrobe_t strobes;

  dbg_cause_ctrl #(.LEVEL_W(LEVEL_W)) u_ctrl (
    .evtValid(evtValid), .curLevel(curLevel), .iCountHit(iCountHit),
    .iBreakHit(iBreakHit), .dBreakAny(|dBreakHit), .swBreakWide(swBreakWide),
    .swBreakNarrow(swBreakNarrow), .strobes(strobes)
  );

  dbg_cause_dp #(.ADDR_W(ADDR_W), .NUM_DBREAK(NUM_DBREAK)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .evtPc(evtPc),
    .dBreakHit(dBreakHit), .causeOut(causeOut), .epcOut(epcOut),
    .psLowOut(psLowOut), .vecRedirect(vecRedirect)
  );
endmodule

// File: rtl/dbg_cause_arb_chk.sv
module dbg_cause_arb_chk #(
  parameter int ADDR_W = 32,
  parameter int LEVEL_W = 4,
  parameter int NUM_DBREAK = 2,
  parameter int CAUSE_W = 9
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  evtValid,
  input logic [ADDR_W-1:0]     evtPc,
  input logic [LEVEL_W-1:0]    curLevel,
  input logic                  iCountHit,
  input logic                  iBreakHit,
  input logic [NUM_DBREAK-1:0] dBreakHit,
  input logic                  swBreakWide,
  input logic                  swBreakNarrow,
  input logic [CAUSE_W-1:0]    causeOut,
  input logic [ADDR_W-1:0]     epcOut,
  input logic [4:0]            psLowOut,
  input logic                  vecRedirect
);
  logic anyEvt;
  logic accept;
  assign anyEvt = iCountHit | iBreakHit | (|dBreakHit) | swBreakWide | swBreakNarrow;
  assign accept = evtValid && anyEvt && (curLevel < LEVEL_W'(6));

  a_r1_accept_redirect: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> vecRedirect);
  a_r2_masked_no_redirect: assert property (@(posedge clk) disable iff (!rstN)
    (curLevel >= LEVEL_W'(6)) |=> !vecRedirect);
  a_r3_status_low: assert property (@(posedge clk) disable iff (!rstN)
    vecRedirect |-> psLowOut == 5'h16);
  a_r4_epc_capture: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> epcOut == $past(evtPc));
  a_r5_icount_code: assert property (@(posedge clk) disable iff (!rstN)
    (accept && iCountHit) |=> causeOut == CAUSE_W'(1));
  a_r7_single_cause: assert property (@(posedge clk) disable iff (!rstN)
    vecRedirect |-> $countones(causeOut[4:0]) == 1);
  a_r9_hold_cause: assert property (@(posedge clk) disable iff (!rstN)
    !accept |=> $stable(causeOut) && $stable(epcOut));
endmodule

bind dbg_cause_arb dbg_cause_arb_chk #(
  .ADDR_W(ADDR_W), .LEVEL_W(LEVEL_W), .NUM_DBREAK(NUM_DBREAK), .CAUSE_W(8 + IDX_W)
) u_chk (.*);

// File: tb/dbg_cause_arb_bench.sv
`timescale 1ns/1ps
module dbg_cause_arb_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic evtValid = 1'b0;
  logic [31:0] evtPc = '0;
  logic [3:0] curLevel = '0;
  logic iCountHit = 1'b0, iBreakHit = 1'b0, swBreakWide = 1'b0, swBreakNarrow = 1'b0;
  logic [1:0] dBreakHit = '0;
  logic [8:0] causeOut;
  logic [31:0] epcOut;
  logic [4:0] psLowOut;
  logic vecRedirect;
  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  dbg_cause_arb u_dbg_cause_arb (
    .clk(clk), .rstN(rstN), .evtValid(evtValid), .evtPc(evtPc), .curLevel(curLevel),
    .iCountHit(iCountHit), .iBreakHit(iBreakHit), .dBreakHit(dBreakHit),
    .swBreakWide(swBreakWide), .swBreakNarrow(swBreakNarrow), .causeOut(causeOut),
    .epcOut(epcOut), .psLowOut(psLowOut), .vecRedirect(vecRedirect)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Present one instruction's events for one edge; return at the next negedge.
  task automatic fire(input logic [3:0] lvl, input logic [31:0] pc, input logic ic,
                      input logic ib, input logic [1:0] db, input logic sw, input logic sn,
                      input logic vld);
    @(negedge clk);
    evtValid = vld; curLevel = lvl; evtPc = pc;
    iCountHit = ic; iBreakHit = ib; dBreakHit = db; swBreakWide = sw; swBreakNarrow = sn;
    @(negedge clk);
    evtValid = 1'b0; iCountHit = 1'b0; iBreakHit = 1'b0; dBreakHit = '0;
    swBreakWide = 1'b0; swBreakNarrow = 1'b0;
  endtask

  task automatic expectTake(input string req, input logic [31:0] pc, input logic [8:0] cause);
    check({req, " redirect"}, 32'(vecRedirect), 32'd1);
    check({req, " cause"}, 32'(causeOut), 32'(cause));
    check({req, " epc R4"}, epcOut, pc);
    check({req, " status R3"}, 32'(psLowOut), 32'h16);
  endtask

  task automatic testReset();
    check("R8 cause", 32'(causeOut), 0);
    check("R8 epc", epcOut, 0);
    check("R8 status", 32'(psLowOut), 0);
    check("R8 redirect", 32'(vecRedirect), 0);
  endtask

  task automatic testSingleCauses();
    fire(4'd5, 32'h1000, 0, 0, 2'b00, 1, 0, 1); expectTake("R5 wide", 32'h1000, 9'h008);
    @(negedge clk); check("R1 pulse ends", 32'(vecRedirect), 0);
    fire(4'd0, 32'h1004, 0, 0, 2'b00, 0, 1, 1); expectTake("R5 narrow", 32'h1004, 9'h010);
    fire(4'd3, 32'h1008, 0, 1, 2'b00, 0, 0, 1); expectTake("R5 ibreak", 32'h1008, 9'h002);
    fire(4'd5, 32'h100c, 1, 0, 2'b00, 0, 0, 1); expectTake("R5 icount", 32'h100c, 9'h001);
    fire(4'd1, 32'h1010, 0, 0, 2'b01, 0, 0, 1); expectTake("R6 dbreak0", 32'h1010, 9'h004);
    fire(4'd1, 32'h1014, 0, 0, 2'b10, 0, 0, 1); expectTake("R6 dbreak1", 32'h1014, 9'h104);
  endtask

  task automatic testPriority();
    fire(4'd5, 32'h2000, 0, 1, 2'b00, 1, 0, 1); expectTake("R7 ibreak over wide", 32'h2000, 9'h002);
    fire(4'd5, 32'h2004, 1, 1, 2'b10, 0, 0, 1); expectTake("R7 icount first", 32'h2004, 9'h001);
    fire(4'd2, 32'h2008, 0, 0, 2'b10, 1, 1, 1); expectTake("R7 dbreak over sw", 32'h2008, 9'h104);
    fire(4'd2, 32'h200c, 0, 0, 2'b00, 1, 1, 1); expectTake("R7 wide over narrow", 32'h200c, 9'h008);
    fire(4'd2, 32'h2010, 0, 0, 2'b11, 0, 0, 1); expectTake("R6 lowest index", 32'h2010, 9'h004);
  endtask

  task automatic testMasking();
    fire(4'd4, 32'h3000, 0, 0, 2'b00, 0, 1, 1); expectTake("R1 setup", 32'h3000, 9'h010);
    fire(4'd6, 32'h3004, 1, 1, 2'b11, 1, 1, 1);
    check("R2 lvl6 redirect", 32'(vecRedirect), 0);
    check("R2 lvl6 cause", 32'(causeOut), 32'h010);
    check("R2 lvl6 epc", epcOut, 32'h3000);
    fire(4'd7, 32'h3008, 0, 1, 2'b00, 1, 0, 1);
    check("R2 lvl7 redirect", 32'(vecRedirect), 0);
    check("R2 lvl7 cause", 32'(causeOut), 32'h010);
    fire(4'd15, 32'h300c, 1, 0, 2'b00, 0, 0, 1);
    check("R2 lvl15 epc", epcOut, 32'h3000);
    fire(4'd2, 32'h3010, 1, 1, 2'b01, 1, 0, 0);
    check("R9 invalid redirect", 32'(vecRedirect), 0);
    check("R9 invalid cause", 32'(causeOut), 32'h010);
    fire(4'd2, 32'h3014, 0, 0, 2'b00, 0, 0, 1);
    check("R9 no event redirect", 32'(vecRedirect), 0);
    check("R9 no event epc", epcOut, 32'h3000);
    check("R9 no event status", 32'(psLowOut), 32'h16);
  endtask

  task automatic testReassertReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    testReset();
    rstN = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testSingleCauses();
    testPriority();
    testMasking();
    testReassertReset();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end
endmodule